// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from an undefined post-power state to a usable one. After reset it keeps the command bus at no-operation for a programmable number of clock cycles, with clock-enable and the byte masks held high. The pause length is sized by the integrator to cover the 200 µs settle time at the chosen clock. It then closes every bank with one precharge-all command and issues a counted group of auto-refresh commands. It finishes by loading the memory's mode register from an input word.

Each command is followed by a fixed number of idle cycles before the next one is issued. These are the row-precharge time after the precharge, the refresh cycle time after each refresh, and the mode-register settle time after the load. Once the last of these waits has expired, a ready flag rises and holds until the next reset. At that point the byte masks are released and a normal controller can take over the pins. Every pin is driven from a register, so the command timing seen on the pins does not depend on combinational paths.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high (sampled on the rising clock edge), the pins show no-operation, clock-enable is high, every mask bit is high, the address and bank are zero, and ready is low.
- R2: After reset is released, exactly PAUSE_CYC no-operation cycles appear on the pins before the precharge. Every mask bit stays high until ready rises.
- R3: The precharge command drives address bit 10 high and all other address bits and the bank select low, so that every bank is closed.
- R4: The first auto-refresh appears exactly T_RP_CYC cycles after the precharge.
- R5: Exactly REF_COUNT auto-refresh commands are issued, each one T_RC_CYC cycles after the one before it.
- R6: The mode-register load appears exactly T_RC_CYC cycles after the last refresh. It carries mode_word on address bits 9..0, with bit 10 low and the bank low. In the expected mode word, bits 6..4 hold the CAS latency (010 = 2, 011 = 3), bit 3 the burst type and bits 2..0 the burst length.
- R7: Ready rises exactly T_RSC_CYC cycles after the mode-register load, and the mask bits fall in the same cycle. After that, ready stays high and the command pins stay at no-operation until the next reset.
- R8: Clock-enable is high in every cycle, both during reset and after it.
- R9: Command pins (cs_n, ras_n, cas_n, we_n) use these encodings: no-operation 0111, precharge 0010, auto-refresh 0001, mode load 0000. No other code ever appears. Each non-idle command lasts one cycle and is followed by no-operation.
- R10: A reset raised partway through the sequence returns the pins to the R1 state. After release, the whole sequence runs again, starting with a full pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 10 | Value placed on address bits 9..0 during the mode-register load |
| cke | output | 1 | Clock-enable to the memory |
| dqm | output | DQM_W | Byte masks, high until ready |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ADDR_W | Multiplexed address; bit 10 marks the precharge-all |
| ready | output | 1 | High once initialization has completed; held until reset |

## Verification
The hardest situation to reach is a reset that arrives while the refresh group is half done. In that case the refresh tally, the gap timer and the state must all return to their starting values together, or the re-run will either skip refreshes or shorten the pause. The stimulus counts refresh commands on the pins, raises reset right after the third one, and then measures the complete second run cycle by cycle against the same timing limits as a clean boot. Small timing parameters keep each run short enough to repeat this with several mode words.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Address bit that selects "all banks" on precharge; mode field sits below it
    localparam int unsigned AP_BIT = 10;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } boot_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECH,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_LOAD_MODE,
        ST_WAIT_RSC,
        ST_DONE
    } boot_state_e;

    // What the sequencer wants on the pins in the next cycle
    typedef struct packed {
        boot_cmd_e cmd;
        logic      all_banks;  // drive the precharge-all address bit
        logic      use_mode;   // drive the mode word on the low address bits
    } cmd_slot_t;

    localparam cmd_slot_t SLOT_IDLE = '{cmd: CMD_NOP, all_banks: 1'b0, use_mode: 1'b0};

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Last cycle of the current wait
    assign expire = (cnt_q == W'(1));
endmodule

// File: rtl/boot_ref_tally.sv
module boot_ref_tally #(
    parameter int unsigned COUNT = 8,
    parameter int unsigned W     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    output logic all_done
);
    logic [W-1:0] tally_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tally_q <= '0;
        end else if (bump && (tally_q != W'(COUNT))) begin
            tally_q <= tally_q + 1'b1;
        end
    end

    assign all_done = (tally_q == W'(COUNT));
endmodule

// File: rtl/boot_pin_reg.sv
module boot_pin_reg
    import sdram_boot_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned BA_W   = 1,
    parameter int unsigned DQM_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_slot_t         slot,
    input  logic              finished,
    input  logic [AP_BIT-1:0] mode_word,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cke                      <= 1'b1;
            dqm                      <= '1;
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            ba                       <= '0;
            addr                     <= '0;
            ready                    <= 1'b0;
        end else begin
            cke                      <= 1'b1;
            dqm                      <= finished ? '0 : '1;
            {cs_n, ras_n, cas_n, we_n} <= slot.cmd;
            ba                       <= '0;
            addr                     <= '0;
            if (slot.use_mode) begin
                addr[AP_BIT-1:0]     <= mode_word;
            end
            addr[AP_BIT]             <= slot.all_banks;
            ready                    <= finished;
        end
    end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int unsigned PAUSE_CYC = 25000,
    parameter int unsigned T_RP_CYC  = 3,
    parameter int unsigned T_RC_CYC  = 9,
    parameter int unsigned T_RSC_CYC = 2,
    parameter int unsigned REF_COUNT = 8,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BA_W      = 1,
    parameter int unsigned DQM_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AP_BIT-1:0] mode_word,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    localparam int unsigned GAP_MAX = max_of(T_RC_CYC, max_of(T_RP_CYC, T_RSC_CYC));
    localparam int unsigned TMR_W   = width_for(max_of(PAUSE_CYC, GAP_MAX));
    localparam int unsigned TAL_W   = width_for(REF_COUNT);

    localparam logic [TMR_W-1:0] LD_RP  = TMR_W'(T_RP_CYC - 1);
    localparam logic [TMR_W-1:0] LD_RC  = TMR_W'(T_RC_CYC - 1);
    localparam logic [TMR_W-1:0] LD_RSC = TMR_W'(T_RSC_CYC - 1);

    boot_state_e      state_q, state_d;
    cmd_slot_t        slot;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             ref_bump;
    logic             ref_all_done;

    boot_gap_timer #(
        .W       (TMR_W),
        .RST_VAL (PAUSE_CYC)
    ) i_gap_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    boot_ref_tally #(
        .COUNT (REF_COUNT),
        .W     (TAL_W)
    ) i_ref_tally (
        .clk      (clk),
        .rst      (rst),
        .bump     (ref_bump),
        .all_done (ref_all_done)
    );

    always_comb begin
        state_d  = state_q;
        slot     = SLOT_IDLE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_bump = 1'b0;
        unique case (state_q)
            ST_PAUSE: begin
                if (tmr_expire) state_d = ST_PRECH;
            end
            ST_PRECH: begin
                slot.cmd       = CMD_PRE;
                slot.all_banks = 1'b1;
                tmr_load       = 1'b1;
                tmr_val        = LD_RP;
                state_d        = ST_WAIT_RP;
            end
            ST_WAIT_RP: begin
                if (tmr_expire) state_d = ST_REFRESH;
            end
            ST_REFRESH: begin
                slot.cmd = CMD_REF;
                ref_bump = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = LD_RC;
                state_d  = ST_WAIT_RC;
            end
            ST_WAIT_RC: begin
                if (tmr_expire) state_d = ref_all_done ? ST_LOAD_MODE : ST_REFRESH;
            end
            ST_LOAD_MODE: begin
                slot.cmd      = CMD_MRS;
                slot.use_mode = 1'b1;
                tmr_load      = 1'b1;
                tmr_val       = LD_RSC;
                state_d       = ST_WAIT_RSC;
            end
            ST_WAIT_RSC: begin
                if (tmr_expire) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: state_d = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PAUSE;
        else     state_q <= state_d;
    end

    boot_pin_reg #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .DQM_W  (DQM_W)
    ) i_pin_reg (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .finished  (state_q == ST_DONE),
        .mode_word (mode_word),
        .cke       (cke),
        .dqm       (dqm),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .ready     (ready)
    );
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
    parameter int unsigned T_RP_CYC  = 3,
    parameter int unsigned T_RC_CYC  = 9,
    parameter int unsigned REF_COUNT = 8,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned DQM_W     = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [9:0]        mode_word,
    input logic [DQM_W-1:0]  dqm,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ready
);
    logic [3:0]  code;
    logic [3:0]  last_code_q;
    logic [15:0] gap_q;
    logic [15:0] refs_q;

    assign code = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            last_code_q <= 4'b0111;
            gap_q       <= '0;
            refs_q      <= '0;
        end else begin
            if (code != 4'b0111) begin
                last_code_q <= code;
                gap_q       <= 16'd1;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 16'd1;
            end
            if (code == 4'b0001) refs_q <= refs_q + 16'd1;

            if (code == 4'b0001 && last_code_q == 4'b0010)
                assert_first_ref_gap_R4: assert (gap_q == 16'(T_RP_CYC));
            if (code == 4'b0001 && last_code_q == 4'b0001)
                assert_ref_spacing_R5: assert (gap_q == 16'(T_RC_CYC));
            if (code == 4'b0000)
                assert_ref_total_R5: assert (refs_q == 16'(REF_COUNT) && gap_q == 16'(T_RC_CYC));
        end
    end

    assert_pre_all_R3: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0010) |-> addr[10]);

    assert_mode_load_R6: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0000) |-> (!addr[10] && addr[9:0] == $past(mode_word)));

    assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_quiet_after_ready_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> (code == 4'b0111));

    assert_mask_until_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (&dqm));

    assert_single_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (code != 4'b0111) |=> (code == 4'b0111));

    assert_legal_code_R9: assert property (@(posedge clk) disable iff (rst)
        (code == 4'b0111) || (code == 4'b0010) || (code == 4'b0001) || (code == 4'b0000));
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
    .T_RP_CYC  (T_RP_CYC),
    .T_RC_CYC  (T_RC_CYC),
    .REF_COUNT (REF_COUNT),
    .ADDR_W    (ADDR_W),
    .DQM_W     (DQM_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_word (mode_word),
    .dqm       (dqm),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ready     (ready)
);

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;
    localparam int P_PAUSE = 40;
    localparam int P_RP    = 3;
    localparam int P_RC    = 7;
    localparam int P_RSC   = 2;
    localparam int P_REFS  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  mode_word = '0;
    logic        cke;
    logic [1:0]  dqm;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [0:0]  ba;
    logic [10:0] addr;
    logic        ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_boot_seq #(
        .PAUSE_CYC (P_PAUSE),
        .T_RP_CYC  (P_RP),
        .T_RC_CYC  (P_RC),
        .T_RSC_CYC (P_RSC),
        .REF_COUNT (P_REFS)
    ) i_sdram_boot_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_word (mode_word),
        .cke       (cke),
        .dqm       (dqm),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .ready     (ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pin_code();
        return int'({cs_n, ras_n, cas_n, we_n});
    endfunction

    // R1 / R8: state of the pins while reset is held
    task automatic check_reset_pins(input string tag);
        check({tag, " R1 cmd"}, pin_code(), 4'b0111);
        check({tag, " R8 cke"}, int'(cke), 1);
        check({tag, " R1 dqm"}, int'(dqm), 2'b11);
        check({tag, " R1 addr"}, int'(addr), 0);
        check({tag, " R1 ba"}, int'(ba), 0);
        check({tag, " R1 ready"}, int'(ready), 0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_pins("reset");
        rst = 1'b0;
    endtask

    // Follows one complete boot from reset release and checks every timing point
    task automatic run_and_check(input logic [9:0] mw);
        int t_pre = -1;
        int t_mrs = -1;
        int t_rdy = -1;
        int nref  = 0;
        int t_ref [16];
        int prev  = 4'b0111;
        for (int t = 1; t <= P_PAUSE + 200 && t_rdy < 0; t++) begin
            int c;
            @(negedge clk);
            c = pin_code();
            check("R8 cke high", int'(cke), 1);
            if (prev != 4'b0111 && c != 4'b0111) check("R9 back-to-back command", c, 4'b0111);
            prev = c;
            if (!ready) check("R2 mask held", int'(dqm), 2'b11);
            case (c)
                4'b0111: ;
                4'b0010: begin
                    t_pre = t;
                    check("R3 precharge addr", int'(addr), 1 << 10);
                    check("R3 precharge bank", int'(ba), 0);
                end
                4'b0001: begin
                    if (nref < 16) t_ref[nref] = t;
                    nref++;
                end
                4'b0000: begin
                    t_mrs = t;
                    check("R6 mode addr", int'(addr), int'(mw));
                    check("R6 mode bank", int'(ba), 0);
                end
                default: check("R9 illegal code", c, 4'b0111);
            endcase
            if (ready) begin
                t_rdy = t;
                check("R7 mask released", int'(dqm), 0);
            end
        end
        check("R2 pause length", t_pre - 1, P_PAUSE);
        check("R4 first refresh gap", t_ref[0] - t_pre, P_RP);
        check("R5 refresh count", nref, P_REFS);
        for (int i = 1; i < P_REFS && i < nref; i++)
            check("R5 refresh spacing", t_ref[i] - t_ref[i-1], P_RC);
        if (nref >= P_REFS) check("R6 mode load gap", t_mrs - t_ref[P_REFS-1], P_RC);
        check("R7 ready delay", t_rdy - t_mrs, P_RSC);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R7 ready held", int'(ready), 1);
            check("R7 idle after ready", pin_code(), 4'b0111);
        end
    endtask

    task automatic scen_boot_cl2_seq_bl4();
        mode_word = 10'h022;  // CL 2, sequential, burst 4
        apply_reset();
        run_and_check(10'h022);
    endtask

    task automatic scen_boot_cl3_intl_bl8();
        mode_word = 10'h03B;  // CL 3, interleave, burst 8
        apply_reset();
        run_and_check(10'h03B);
    endtask

    task automatic scen_boot_single_write();
        mode_word = 10'h232;  // single write, CL 3, sequential, burst 4
        apply_reset();
        run_and_check(10'h232);
    endtask

    // R10: reset partway through the refresh group restarts the whole sequence
    task automatic scen_midway_reset();
        int seen = 0;
        mode_word = 10'h022;
        apply_reset();
        for (int t = 0; t < P_PAUSE + 100 && seen < 3; t++) begin
            @(negedge clk);
            if (pin_code() == 4'b0001) seen++;
        end
        check("R10 reached third refresh", seen, 3);
        rst = 1'b1;
        @(negedge clk);
        check_reset_pins("R10 midway");
        @(negedge clk);
        rst = 1'b0;
        mode_word = 10'h03B;
        run_and_check(10'h03B);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        scen_boot_cl2_seq_bl4();
        scen_boot_cl3_intl_bl8();
        scen_midway_reset();
        scen_boot_single_write();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule